// File: doc/BRIEF.md
# Four-Lane Stereo Serial Audio Transmitter

This block turns parallel stereo samples into a serial audio stream for an external converter. It runs from a master clock at 768 times the sample rate. From that clock it makes a bit clock, a left/right word clock and a second word clock at twice the sample rate. Four serial data pins shift out in lockstep. Each pin carries one source: FM only, wavetable only, the FM plus wavetable mix, and the effect-send wavetable signal.

Once per frame, every lane's left and right samples are captured together into shadow registers. A one-cycle request strobe marks that moment, so the upstream mixer knows when the next set is needed. Each channel slot is 24 bit clocks long. The 16-bit sample is right-justified in its slot and sent MSB first. The leading bits of the slot carry copies of the sign bit.

Top module: `sat_tx`

## Requirements
- R1: `bclk` is the master clock divided by 16. After the frame starts it is low for 8 master cycles and then high for 8 master cycles, with the low phase first.
- R2: `lrclk` is high for the 24 bit periods of the left slot and low for the 24 bit periods of the right slot, so one frame is 48 bit periods. It changes only in a cycle where `bclk` is low.
- R3: `wclk2` is high for the first 12 bit periods of each slot and low for the last 12, giving a frequency of twice the sample rate. Every edge of `lrclk` is also an edge of `wclk2`.
- R4: Within a slot, bit periods 0 to 7 carry sample bit 15 (the sign). Bit periods 8 to 23 carry sample bits 15 down to 0, so the LSB is in the last bit period of the slot.
- R5: Serial data changes only in the master cycle where `bclk` falls. The one exception is the first cycle of the first frame after reset. Data therefore holds steady across each rising edge of `bclk`.
- R6: `sdo[0]` carries the FM pair, `sdo[1]` the wavetable pair, `sdo[2]` the mix pair and `sdo[3]` the effect-send pair. Each lane sends its left sample in the left slot and its right sample in the right slot.
- R7: All eight sample inputs are captured at the clock edge that ends a `req` cycle. `req` is high for exactly one master cycle: the last master cycle of a frame. Captured values go out starting at the next left slot. Input changes at any other time have no effect on the serial data.
- R8: While `rst_n` is sampled low, all clocks, data and `req` are low on the following cycles. After release comes one cycle with `req` high and clocks low. The frame then starts at bit period 0 of the left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 768 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fm_l | input | 16 | FM left sample, two's complement |
| fm_r | input | 16 | FM right sample |
| wt_l | input | 16 | Wavetable left sample |
| wt_r | input | 16 | Wavetable right sample |
| mix_l | input | 16 | FM plus wavetable mix, left |
| mix_r | input | 16 | FM plus wavetable mix, right |
| fx_l | input | 16 | Effect-send wavetable, left |
| fx_r | input | 16 | Effect-send wavetable, right |
| bclk | output | 1 | Bit clock, 48 times the sample rate |
| lrclk | output | 1 | Word clock, high for the left slot |
| wclk2 | output | 1 | Word clock at twice the sample rate |
| sdo | output | 4 | Serial data lanes, bit index as in R6 |
| req | output | 1 | One-cycle strobe marking the sample capture |

## Verification
The bench goes after several corner cases, each with a known failure signature:
- Sign extension with the extreme codes 8000h, 7FFFh, FFFFh and 0001h. A design that zero-pads instead of sign-extending shows wrong leading bits on negative samples. A design with the justification off by one bit shifts the LSB into the next slot.
- Inputs that change on every master cycle between captures. A design that samples at the wrong moment, or keeps sampling, shows values that never appear in the reference model.
- A reset in the middle of a frame. A design that resumes mid-frame, or skips the start-up capture, starts `lrclk` on the wrong slot or sends stale data.
- Lanes with different content. A swapped lane order or a swapped left/right choice shows up within one slot.

// File: rtl/sat_pkg.sv
// Package: shared constants for the four-lane serial audio transmitter.
// Assumes a fixed lane count of four; the lane order is part of the pin contract.
package sat_pkg;
    localparam int SAT_LINES = 4;

    // Lane index on the serial data bus
    typedef enum int {
        LN_FM  = 0,
        LN_WT  = 1,
        LN_MIX = 2,
        LN_FX  = 3
    } sat_lane_e;
endpackage

// File: rtl/sat_timing.sv
// Module: frame timing generator.
// Divides the master clock into bit periods, counts bit periods within a slot
// and alternates left/right slots. Produces the three clocks, the slot
// position and the capture strobe (last master cycle of a frame, or the single
// start-up cycle after reset). Assumes MCLK_DIV is even and SLOT_BITS is even.
module sat_timing #(
    parameter int MCLK_DIV  = 16,
    parameter int SLOT_BITS = 24,
    parameter int MW        = $clog2(MCLK_DIV),
    parameter int SW        = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          run,
    output logic          bclk,
    output logic          lrclk,
    output logic          wclk2,
    output logic          cap,
    output logic [SW-1:0] slot_pos
);
    localparam logic [MW-1:0] MC_LAST = MW'(MCLK_DIV - 1);
    localparam logic [MW-1:0] MC_HALF = MW'(MCLK_DIV / 2);
    localparam logic [SW-1:0] SP_LAST = SW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] SP_HALF = SW'(SLOT_BITS / 2);

    logic          run_q;
    logic          right_q;
    logic [MW-1:0] mc_q;
    logic [SW-1:0] sp_q;
    logic          frame_end;

    // Counter chain: master cycle -> bit period in slot -> slot side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            right_q <= 1'b0;
            mc_q    <= '0;
            sp_q    <= '0;
        end else if (!run_q) begin
            run_q <= 1'b1;
        end else begin
            if (mc_q == MC_LAST) begin
                mc_q <= '0;
                if (sp_q == SP_LAST) begin
                    sp_q    <= '0;
                    right_q <= ~right_q;
                end else begin
                    sp_q <= sp_q + 1'b1;
                end
            end else begin
                mc_q <= mc_q + 1'b1;
            end
        end
    end

    // Decode clocks and strobes from the counter state
    always_comb begin
        frame_end = run_q && right_q && (mc_q == MC_LAST) && (sp_q == SP_LAST);
        cap       = !run_q || frame_end;
        bclk      = run_q && (mc_q >= MC_HALF);
        lrclk     = run_q && !right_q;
        wclk2     = run_q && (sp_q < SP_HALF);
        run       = run_q;
        slot_pos  = sp_q;
    end
endmodule

// File: rtl/sat_capture.sv
// Module: per-frame sample shadow registers.
// Holds one left/right pair per lane; all pairs load together on cap.
// Assumes cap is a single-cycle strobe from the timing generator.
module sat_capture #(
    parameter int LINES = 4,
    parameter int W     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap,
    input  logic [LINES-1:0][W-1:0]  in_l,
    input  logic [LINES-1:0][W-1:0]  in_r,
    output logic [LINES-1:0][W-1:0]  sh_l,
    output logic [LINES-1:0][W-1:0]  sh_r
);
    // Load all shadow pairs at once on the capture strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_l <= '0;
            sh_r <= '0;
        end else if (cap) begin
            sh_l <= in_l;
            sh_r <= in_r;
        end
    end
endmodule

// File: rtl/sat_lane.sv
// Module: slot bit selector for one serial lane.
// Picks the bit for the current slot position: the sign bit during the
// leading pad, then MSB to LSB so the sample ends on the last slot bit.
// Assumes SLOT_BITS >= W.
module sat_lane #(
    parameter int W         = 16,
    parameter int SLOT_BITS = 24,
    parameter int SW        = $clog2(SLOT_BITS)
) (
    input  logic          run,
    input  logic [SW-1:0] slot_pos,
    input  logic [W-1:0]  sample,
    output logic          sd
);
    localparam logic [SW-1:0] PAD_T  = SW'(SLOT_BITS - W);
    localparam logic [SW-1:0] MSB_T  = SW'(W - 1);
    localparam logic [SW-1:0] LAST_T = SW'(SLOT_BITS - 1);

    logic [SW-1:0] sel;
    logic [W-1:0]  shifted;

    // Map slot position to sample bit, sign-extending in the pad
    always_comb begin
        sel     = (slot_pos < PAD_T) ? MSB_T : (LAST_T - slot_pos);
        shifted = sample >> sel;
        sd      = run && shifted[0];
    end
endmodule

// File: rtl/sat_tx.sv
// Module: four-lane stereo serial audio transmitter (top).
// Builds the bit clock and the two word clocks from the master clock, captures
// all four stereo pairs once per frame and shifts each lane out right-justified
// in 24-bit slots. Assumes the master clock is 768 times the sample rate.
module sat_tx
    import sat_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int MCLK_DIV  = 16,
    parameter int SLOT_BITS = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SAMPLE_W-1:0]  fm_l,
    input  logic [SAMPLE_W-1:0]  fm_r,
    input  logic [SAMPLE_W-1:0]  wt_l,
    input  logic [SAMPLE_W-1:0]  wt_r,
    input  logic [SAMPLE_W-1:0]  mix_l,
    input  logic [SAMPLE_W-1:0]  mix_r,
    input  logic [SAMPLE_W-1:0]  fx_l,
    input  logic [SAMPLE_W-1:0]  fx_r,
    output logic                 bclk,
    output logic                 lrclk,
    output logic                 wclk2,
    output logic [SAT_LINES-1:0] sdo,
    output logic                 req
);
    localparam int SW = $clog2(SLOT_BITS);

    logic                               run;
    logic                               cap;
    logic [SW-1:0]                      slot_pos;
    logic [SAT_LINES-1:0][SAMPLE_W-1:0] in_l, in_r, sh_l, sh_r;

    // Arrange sample ports in lane order
    always_comb begin
        in_l[LN_FM]  = fm_l;   in_r[LN_FM]  = fm_r;
        in_l[LN_WT]  = wt_l;   in_r[LN_WT]  = wt_r;
        in_l[LN_MIX] = mix_l;  in_r[LN_MIX] = mix_r;
        in_l[LN_FX]  = fx_l;   in_r[LN_FX]  = fx_r;
    end

    sat_timing #(.MCLK_DIV(MCLK_DIV), .SLOT_BITS(SLOT_BITS)) u_timing (
        .clk(clk), .rst_n(rst_n), .run(run), .bclk(bclk), .lrclk(lrclk),
        .wclk2(wclk2), .cap(cap), .slot_pos(slot_pos)
    );

    sat_capture #(.LINES(SAT_LINES), .W(SAMPLE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .cap(cap), .in_l(in_l), .in_r(in_r),
        .sh_l(sh_l), .sh_r(sh_r)
    );

    for (genvar i = 0; i < SAT_LINES; i++) begin : g_lane
        logic [SAMPLE_W-1:0] cur;
        // Left shadow during the left slot, right shadow otherwise
        assign cur = lrclk ? sh_l[i] : sh_r[i];
        sat_lane #(.W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_lane (
            .run(run), .slot_pos(slot_pos), .sample(cur), .sd(sdo[i])
        );
    end

    // Request strobe is held off while reset is applied
    assign req = rst_n && cap;
endmodule

// File: rtl/sat_tx_chk.sv
// Module: protocol checker for sat_tx, bound onto every instance.
// Observes only the top-level ports.
module sat_tx_chk #(
    parameter int LINES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk,
    input logic             lrclk,
    input logic             wclk2,
    input logic [LINES-1:0] sdo,
    input logic             req
);
    // R7: the request strobe lasts one master cycle
    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R7: the cycle after a capture opens the left slot
    assert_req_then_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> lrclk);

    // R2: word clock edges fall in a bclk-low cycle
    assert_lr_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(lrclk)) |-> !bclk);

    // R3: each lrclk edge coincides with a wclk2 edge
    assert_wclk_follows_lr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(lrclk)) |-> !$stable(wclk2));

    // R5: data moves only where bclk falls, or at the very first frame start
    assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(sdo)) |-> (!bclk && ($past(bclk) || $rose(lrclk))));
endmodule

bind sat_tx sat_tx_chk #(.LINES(4)) u_sat_tx_chk (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
    .wclk2(wclk2), .sdo(sdo), .req(req)
);

// File: tb/tb_sat_tx.sv
// Bench: behavioural frame model compared against sat_tx on every master clock.
module tb_sat_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] smp [4][2];
    logic        bclk, lrclk, wclk2, req;
    logic [3:0]  sdo;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    // Reference model state
    bit          m_run = 1'b0;
    int          m_t = 0;
    logic [15:0] m_sh [4][2];

    always #4 clk = ~clk;

    sat_tx dut (
        .clk(clk), .rst_n(rst_n),
        .fm_l(smp[0][0]), .fm_r(smp[0][1]),
        .wt_l(smp[1][0]), .wt_r(smp[1][1]),
        .mix_l(smp[2][0]), .mix_r(smp[2][1]),
        .fx_l(smp[3][0]), .fx_r(smp[3][1]),
        .bclk(bclk), .lrclk(lrclk), .wclk2(wclk2), .sdo(sdo), .req(req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int l = 0; l < 4; l++)
            for (int c = 0; c < 2; c++) begin
                smp[l][c] = '0;
                m_sh[l][c] = '0;
            end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    always @(negedge clk) begin
        int bitn, s, idx, ch;
        int e_bclk, e_lr, e_w, e_req, e_sdo;
        // 1) advance model over the posedge just passed
        if (!rst_n) begin
            m_run = 1'b0; m_t = 0;
            for (int l = 0; l < 4; l++) begin m_sh[l][0] = '0; m_sh[l][1] = '0; end
        end else if (!m_run || m_t == 767) begin
            if (m_run) m_t = 0;
            m_run = 1'b1;
            for (int l = 0; l < 4; l++) begin m_sh[l][0] = smp[l][0]; m_sh[l][1] = smp[l][1]; end
        end else begin
            m_t++;
        end

        // 2) compare outputs against the model
        bitn   = m_t / 16;
        s      = bitn % 24;
        ch     = (bitn < 24) ? 0 : 1;
        idx    = (s < 8) ? 15 : 23 - s;
        e_bclk = (m_run && (m_t % 16) >= 8) ? 1 : 0;
        e_lr   = (m_run && bitn < 24) ? 1 : 0;
        e_w    = (m_run && s < 12) ? 1 : 0;
        e_req  = (rst_n && (!m_run || m_t == 767)) ? 1 : 0;
        e_sdo  = 0;
        if (m_run)
            for (int l = 0; l < 4; l++) e_sdo |= int'(m_sh[l][ch][idx]) << l;
        if (!m_run) begin
            // R8: quiet outputs in and just after reset
            chk("R8 clocks/data low", {bclk, lrclk, wclk2, sdo}, 0);
        end
        chk("R1 bclk", bclk, e_bclk);
        chk("R2 lrclk", lrclk, e_lr);
        chk("R3 wclk2", wclk2, e_w);
        // R4 justification, R5 change timing, R6 lane order
        chk("R4/R5/R6 sdo", sdo, e_sdo);
        chk("R7 req", req, e_req);

        // 3) drive the next inputs
        cyc++;
        if (cyc == 6) rst_n = 1'b1;
        if (cyc == 5000) rst_n = 1'b0;     // R8: reset in mid-frame
        if (cyc == 5003) rst_n = 1'b1;
        if (cyc >= 1500 && cyc < 3100) begin
            // R4: extreme codes held steady over two frames
            smp[0][0] = 16'h8000; smp[0][1] = 16'h7FFF;
            smp[1][0] = 16'hFFFF; smp[1][1] = 16'h0001;
            smp[2][0] = 16'h0000; smp[2][1] = 16'h8001;
            smp[3][0] = 16'h7FFE; smp[3][1] = 16'hA55A;
        end else begin
            // R7: inputs churn every cycle; only captures matter
            for (int l = 0; l < 4; l++)
                for (int c = 0; c < 2; c++) smp[l][c] = 16'($urandom);
        end
        if (cyc == 9000) begin
            done = 1'b1;
            finish_run();
        end
    end
endmodule